// File: doc/BRIEF.md
# Bonded Lane Start Synchronizer

This block makes a group of N bonded transmit lanes begin their traffic on one common clock cycle. One lane, chosen by a parameter, is the master. It accepts a single-cycle start request and launches a start token. The token does not fan out to all lanes at once. It passes from each lane to its neighbour, outward from the master in both directions along an ordered, contiguous chain. Every hop between neighbours costs a fixed number of parallel-clock cycles.

Each lane knows how many hops separate it from the master. It holds the arriving token for a residual delay so that its hop delay plus its residual delay equals the same total for every lane. The farthest lane needs no residual delay, and the master needs the most. All lanes then pulse their start outputs together. Placing the master in the centre of the chain keeps that common total as small as possible.

The block is used beside the transmit datapaths of a bonded group. Each lane's pulse tells its own datapath when to begin.

Top module: `lane_start_sync`

## Requirements
- R1: In every cycle, the bits of `start_o` are either all 0 or all 1. All lanes start in the same cycle.
- R2: An accepted request in cycle c makes every `start_o` bit high in cycle c+TOTAL+1. TOTAL is HOP·max(MASTER, N-1-MASTER), and HOP defaults to 2.
- R3: Each start output is high for exactly one cycle per accepted request.
- R4: A request in cycles c+1 to c+TOTAL after an accepted request in cycle c is ignored. A request in the cycle where the outputs fire is accepted.
- R5: A synchronous active-high reset clears every in-flight start. No start pulse follows a request made before or during reset, and a request during reset is ignored.
- R6: With default parameters (N=6), the master is lane (N-1)/2 = 2. The lane delays from the master are 4,2,0,2,4,6 cycles, and the total is 6.
- R7: R1 to R4 hold for every MASTER from 0 to N-1, including both ends of the chain.
- R8: Without a request, no start output ever goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Single-cycle start request at the master |
| start_o | output | N | Registered start pulse, one bit per lane, bit i is lane i |

## Verification
On every cycle, the assertions check that the lanes fire together, that a pulse lasts one cycle, that a request landing while a start is in flight leaves the in-flight countdown untouched, and that the outputs fire exactly TOTAL+1 cycles after an accepted request. The bench's scenarios are needed for the rest. These are the exact acceptance boundary at the fire cycle, the clearing of an in-flight start by reset, the default centre placement, and the sweep over every master position. That sweep compares each instance against an arithmetic schedule of expected fire cycles.

// File: rtl/lss_pkg.sv
package lss_pkg;

  // Common launch-to-start delay for a chain of n lanes with master m.
  function automatic int unsigned lss_total(int unsigned n, int unsigned m, int unsigned hop);
    return hop * ((m > (n - 1 - m)) ? m : (n - 1 - m));
  endfunction

  // Hop count between lane p and the master m.
  function automatic int unsigned lss_dist(int unsigned p, int unsigned m);
    return (p > m) ? (p - m) : (m - p);
  endfunction

endpackage

// File: rtl/lss_delay.sv
module lss_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_reg
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= (sr << 1) | DEPTH'(d);
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/lss_lane.sv
module lss_lane import lss_pkg::*; #(
  parameter int unsigned N      = 6,
  parameter int unsigned MASTER = 2,
  parameter int unsigned HOP    = 2,
  parameter int unsigned POS    = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic token_in,
  output logic start_q
);
  localparam int unsigned TOTAL = lss_total(N, MASTER, HOP);
  localparam int unsigned COMP  = TOTAL - HOP * lss_dist(POS, MASTER);

  logic token_late;

  lss_delay #(.DEPTH(COMP)) u_comp (
    .clk(clk), .rst(rst), .d(token_in), .q(token_late)
  );

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= token_late;
  end
endmodule

// File: rtl/lane_start_sync.sv
module lane_start_sync import lss_pkg::*; #(
  parameter int unsigned N      = 6,
  parameter int unsigned MASTER = (N - 1) / 2,
  parameter int unsigned HOP    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_req,
  output logic [N-1:0] start_o
);
  localparam int unsigned TOTAL = lss_total(N, MASTER, HOP);
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] busy_cnt;
  logic          launch;
  logic [N-1:0]  chain;

  // Master accepts a request only when no start is in flight.
  assign launch = start_req && (busy_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                  busy_cnt <= '0;
    else if (launch)          busy_cnt <= CW'(TOTAL);
    else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
  end

  // Token ripples outward from the master, one hop per neighbour.
  generate
    for (genvar p = 0; p < N; p++) begin : g_lane
      if (p == MASTER) begin : g_src
        assign chain[p] = launch;
      end else if (p < MASTER) begin : g_down
        lss_delay #(.DEPTH(HOP)) u_hop (
          .clk(clk), .rst(rst), .d(chain[p+1]), .q(chain[p])
        );
      end else begin : g_up
        lss_delay #(.DEPTH(HOP)) u_hop (
          .clk(clk), .rst(rst), .d(chain[p-1]), .q(chain[p])
        );
      end

      lss_lane #(.N(N), .MASTER(MASTER), .HOP(HOP), .POS(p)) u_lane (
        .clk(clk), .rst(rst), .token_in(chain[p]), .start_q(start_o[p])
      );
    end
  endgenerate
endmodule

// File: rtl/lss_checker.sv
module lss_checker import lss_pkg::*; #(
  parameter int unsigned N      = 6,
  parameter int unsigned MASTER = 2,
  parameter int unsigned HOP    = 2,
  parameter int unsigned CW     = $clog2(lss_total(N, MASTER, HOP) + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_req,
  input logic [N-1:0]  start_o,
  input logic [CW-1:0] busy_cnt
);
  localparam int unsigned TOTAL = lss_total(N, MASTER, HOP);
  localparam int unsigned AW    = $clog2(TOTAL + 2) + 1;

  logic          armed;
  logic [AW-1:0] age;
  logic          accept;

  assign accept = start_req && (busy_cnt == '0);

  // Independent age counter: cycles since the last accepted request.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      age   <= '0;
    end else if (accept) begin
      armed <= 1'b1;
      age   <= AW'(1);
    end else if (armed && age == AW'(TOTAL + 1)) begin
      armed <= 1'b0;
    end else if (armed) begin
      age <= age + 1'b1;
    end
  end

  p_all_or_none_r1: assert property (@(posedge clk) disable iff (rst)
    ($countones(start_o) == 0) || ($countones(start_o) == N));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (start_o != '0) == (armed && age == AW'(TOTAL + 1)));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (start_o != '0) |=> (start_o == '0));

  p_ignore_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (start_req && busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - CW'(1)));
endmodule

bind lane_start_sync lss_checker #(.N(N), .MASTER(MASTER), .HOP(HOP)) u_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .start_o(start_o), .busy_cnt(busy_cnt)
);

// File: tb/lane_start_sync_bench.sv
`timescale 1ns/1ps
module lane_start_sync_bench;
  localparam int NI = 7; // 0..5 sweep masters with N=6, 6 = default instance

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic [5:0] outs [NI];

  always #10 clk = ~clk; // 50 MHz

  // Default-parameter instance (R6).
  lane_start_sync u_lane_start_sync (
    .clk(clk), .rst(rst), .start_req(start_req), .start_o(outs[6])
  );

  // Sweep over every master position (R7).
  generate
    for (genvar m = 0; m < 6; m++) begin : g_sweep
      lane_start_sync #(.N(6), .MASTER(m)) u_lane_start_sync (
        .clk(clk), .rst(rst), .start_req(start_req), .start_o(outs[m])
      );
    end
  endgenerate

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int tot      [NI];
  int last_acc [NI];
  int prev_acc [NI];
  string tag = "R5";

  task automatic check_cycle();
    for (int i = 0; i < NI; i++) begin
      logic fire;
      logic [5:0] expv;
      fire = (last_acc[i] == cyc - tot[i] - 1) || (prev_acc[i] == cyc - tot[i] - 1);
      expv = fire ? 6'h3f : 6'h00;
      vectors++;
      if (outs[i] !== expv) begin
        errors++;
        $display("FAIL %s %s inst=%0d cycle=%0d actual=%b expected=%b",
                 tag, (i == 6) ? "R6" : "R7", i, cyc, outs[i], expv);
      end
      // R1: lanes never disagree
      vectors++;
      if (!(outs[i] === 6'h00 || outs[i] === 6'h3f)) begin
        errors++;
        $display("FAIL R1 inst=%0d cycle=%0d actual=%b expected=all-equal", i, cyc, outs[i]);
      end
    end
  endtask

  task automatic step(input logic r, input logic rs);
    @(negedge clk);
    check_cycle();
    start_req = r;
    rst       = rs;
    for (int i = 0; i < NI; i++) begin
      if (rs) begin
        last_acc[i] = -1000;
        prev_acc[i] = -1000;
      end else if (r && cyc >= last_acc[i] + tot[i] + 1) begin
        prev_acc[i] = last_acc[i];
        last_acc[i] = cyc;
      end
    end
    cyc++;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) tot[i] = 2 * ((i > 5 - i) ? i : 5 - i);
    tot[6] = 2 * 3; // R6: centre master 2 of 6 lanes, delays 4,2,0,2,4,6
    for (int i = 0; i < NI; i++) begin
      last_acc[i] = -1000;
      prev_acc[i] = -1000;
    end

    // R5: reset state, and a request during reset is ignored
    tag = "R5";
    repeat (3) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);

    // R8: idle, no pulses
    tag = "R8";
    repeat (20) step(1'b0, 1'b0);

    // R2 / R7: isolated requests with varied spacing
    tag = "R2";
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0);
      repeat (20 + k) step(1'b0, 1'b0);
    end

    // R3 / R4: request held high, accepted once per TOTAL+1 cycles
    tag = "R3";
    repeat (40) step(1'b1, 1'b0);
    repeat (15) step(1'b0, 1'b0);

    // R4: second request at every offset up to past the fire cycle
    tag = "R4";
    for (int d = 1; d <= 12; d++) begin
      step(1'b1, 1'b0);
      repeat (d - 1) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      repeat (25) step(1'b0, 1'b0);
    end

    // R5: reset while a start is in flight cancels it
    tag = "R5";
    for (int d = 0; d < 4; d++) begin
      step(1'b1, 1'b0);
      repeat (d) step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      repeat (20) step(1'b0, 1'b0);
    end

    // R5: request right after reset is accepted normally
    step(1'b1, 1'b0);
    repeat (15) step(1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog cycle=%0d actual=running expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule